// File: doc/BRIEF.md
# Burst Header Receiver and Slot Stamper

This block sits at the electrical end of a control channel in a burst-switched core node. Burst header packets arrive as a stream of parallel words, marked by a start-of-frame flag and a valid strobe. The block assembles each header, checks its framing and its even parity, and decodes the destination, burst length, offset, service class and ingress channel fields. Headers that fail a check are dropped, and a one-cycle error pulse is raised that a statistics counter can count.

A free-running slot counter advances on every slot tick and wraps at a programmable modulus. The modulus must be larger than the longest burst plus the largest offset. Each accepted header is stamped with the counter value taken when its first word arrived. From that stamp the block computes the absolute start slot and end slot of the burst, both modulo the counter period. It then emits a trimmed request that carries only the scheduling fields. The request goes out on exactly one of `NUM_DEST` per-egress valid lines, chosen by the destination field.

Top module: `burst_hdr_rx`

## Requirements
- R1: A header is `FRAME_WORDS` words long (2 with the defaults). The first word is presented with `hdrSof` high and the rest with `hdrSof` low. Cycles with `hdrValid` low are gaps and neither advance nor break a frame.
- R2: A word with `hdrValid` high and `hdrSof` low while no frame is open is discarded. `errPulse` is then high for exactly the one cycle after that word.
- R3: A word with `hdrSof` high while a frame is open discards the open frame and raises `errPulse` in the next cycle. That word then starts a new frame, which completes normally.
- R4: The assembled 16-bit header (first word in bits 15:8) has these fields: parity in bit 15, ingress channel in bits 14:12, class in bits 11:10, offset in bits 9:6, burst length in bits 5:2 and destination in bits 1:0.
- R5: The XOR of all 16 header bits must be 0 (even parity). Otherwise the header is discarded, no request is emitted and `errPulse` is high in the cycle after its last word.
- R6: A header whose destination is `NUM_DEST` or greater (3 with the defaults) is discarded with an `errPulse` in the cycle after its last word.
- R7: The slot counter is 0 after reset and advances by one on each cycle with `slotTick` high. It wraps from `CNT_MOD-1` (39 by default) to 0.
- R8: The start slot is TS = (stamp + offset) mod `CNT_MOD`. The stamp is the counter value in the cycle of the header's first word, before any increment from a tick in that same cycle.
- R9: The end slot is TE = (TS + length) mod `CNT_MOD`.
- R10: A header that passes all checks drives exactly `reqValid[dest]` high for one cycle, in the cycle after its last word. At the same time `reqPayload` = {channel[20:18], class[17:16], length[15:12], TS[11:6], TE[5:0]}. `reqValid` and `errPulse` are never high together.
- R11: During and right after reset, `reqValid` and `errPulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrWord | input | WORD_W | Header word from the control channel |
| hdrSof | input | 1 | Marks the first word of a header |
| hdrValid | input | 1 | Word strobe |
| slotTick | input | 1 | One pulse per control slot |
| reqValid | output | NUM_DEST | Per-destination request strobe |
| reqPayload | output | 21 | Channel, class, length, start slot, end slot |
| errPulse | output | 1 | Framing, parity or destination failure |

## Verification
A word index stuck at the wrong value shows up at the next header. Either a spurious `errPulse` appears one cycle after a word, or the `reqValid` expected one cycle after the last word is missing. A slot counter that drifts, wraps at the wrong value or stamps after a same-cycle tick shows up as wrong TS and TE on the next accepted header. The sweep therefore walks the counter through every value and crosses each of them with every offset. It uses length and offset pairs that force both sums past the modulus, so a wrap fault is exposed within one counter period.

// File: rtl/burst_hdr_pkg.sv
package burst_hdr_pkg;
  localparam int DEST_W = 2;
  localparam int LEN_W  = 4;
  localparam int OFF_W  = 4;
  localparam int QOS_W  = 2;
  localparam int CHAN_W = 3;
  localparam int SLOT_W = 6;

  localparam int HDR_W    = 1 + CHAN_W + QOS_W + OFF_W + LEN_W + DEST_W;
  localparam int DEST_LSB = 0;
  localparam int LEN_LSB  = DEST_LSB + DEST_W;
  localparam int OFF_LSB  = LEN_LSB + LEN_W;
  localparam int QOS_LSB  = OFF_LSB + OFF_W;
  localparam int CHAN_LSB = QOS_LSB + QOS_W;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [QOS_W-1:0]  qos;
    logic [LEN_W-1:0]  len;
    logic [SLOT_W-1:0] ts;
    logic [SLOT_W-1:0] te;
  } req_t;

  localparam int REQ_W = $bits(req_t);

  typedef struct packed {
    logic loadFirst;
    logic loadNext;
    logic frameDone;
    logic frameErr;
  } strobe_t;
endpackage

// File: rtl/burst_hdr_ctrl.sv
module burst_hdr_ctrl
  import burst_hdr_pkg::*;
#(
  parameter int FRAME_WORDS = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hdrValid,
  input  logic    hdrSof,
  output strobe_t stb
);
  localparam int IDX_W = (FRAME_WORDS > 2) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

  // 0 means no frame open; k means k words already taken
  logic [IDX_W-1:0] wordIdx, nextIdx;

  always_comb begin
    stb     = '0;
    nextIdx = wordIdx;
    if (hdrValid) begin
      if (hdrSof) begin
        stb.loadFirst = 1'b1;
        stb.frameErr  = (wordIdx != '0);
        nextIdx       = IDX_W'(1);
      end else if (wordIdx == '0) begin
        stb.frameErr = 1'b1;
      end else begin
        stb.loadNext = 1'b1;
        if (wordIdx == LAST_IDX) begin
          stb.frameDone = 1'b1;
          nextIdx       = '0;
        end else begin
          nextIdx = wordIdx + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wordIdx <= '0;
    else       wordIdx <= nextIdx;
  end
endmodule

// File: rtl/burst_hdr_dp.sv
module burst_hdr_dp
  import burst_hdr_pkg::*;
#(
  parameter int NUM_DEST    = 3,
  parameter int CNT_MOD     = 40,
  parameter int WORD_W      = 8,
  parameter int FRAME_WORDS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WORD_W-1:0]   hdrWord,
  input  logic                slotTick,
  input  strobe_t             stb,
  output logic [NUM_DEST-1:0] reqValid,
  output logic [REQ_W-1:0]    reqPayload,
  output logic                errPulse
);
  localparam int PART_W = (FRAME_WORDS - 1) * WORD_W;
  localparam logic [SLOT_W-1:0] CNT_LAST = SLOT_W'(CNT_MOD - 1);
  localparam logic [SLOT_W:0]   MOD_X    = (SLOT_W + 1)'(CNT_MOD);

  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] stampCnt;
  logic [PART_W-1:0] partBuf;
  logic [HDR_W-1:0]  fullHdr;

  function automatic logic [SLOT_W-1:0] modAdd(input logic [SLOT_W-1:0] a,
                                               input logic [SLOT_W-1:0] b);
    logic [SLOT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= MOD_X) s = s - MOD_X;
    return s[SLOT_W-1:0];
  endfunction

  // slot counter with wrap
  always_ff @(posedge clk) begin
    if (!rstN)         slotCnt <= '0;
    else if (slotTick) slotCnt <= (slotCnt == CNT_LAST) ? '0 : slotCnt + SLOT_W'(1);
  end

  // header assembly and arrival stamp
  always_ff @(posedge clk) begin
    if (!rstN) begin
      partBuf  <= '0;
      stampCnt <= '0;
    end else begin
      if (stb.loadFirst || stb.loadNext) partBuf <= PART_W'({partBuf, hdrWord});
      if (stb.loadFirst)                 stampCnt <= slotCnt;
    end
  end

  assign fullHdr = {partBuf, hdrWord};

  logic [DEST_W-1:0] destF;
  logic [LEN_W-1:0]  lenF;
  logic [OFF_W-1:0]  offF;
  logic              parityOk, destOk, accept;
  req_t              reqNext;
  logic [NUM_DEST-1:0] hitVec;

  assign destF    = fullHdr[DEST_LSB +: DEST_W];
  assign lenF     = fullHdr[LEN_LSB +: LEN_W];
  assign offF     = fullHdr[OFF_LSB +: OFF_W];
  assign parityOk = ~^fullHdr;
  assign destOk   = (32'(destF) < NUM_DEST);
  assign accept   = parityOk && destOk;

  always_comb begin
    reqNext.chan = fullHdr[CHAN_LSB +: CHAN_W];
    reqNext.qos  = fullHdr[QOS_LSB +: QOS_W];
    reqNext.len  = lenF;
    reqNext.ts   = modAdd(stampCnt, SLOT_W'(offF));
    reqNext.te   = modAdd(reqNext.ts, SLOT_W'(lenF));
  end

  for (genvar d = 0; d < NUM_DEST; d++) begin : g_route
    assign hitVec[d] = (destF == DEST_W'(d));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid   <= '0;
      errPulse   <= 1'b0;
      reqPayload <= '0;
    end else begin
      reqValid <= (stb.frameDone && accept) ? hitVec : '0;
      errPulse <= stb.frameErr || (stb.frameDone && !accept);
      if (stb.frameDone && accept) reqPayload <= reqNext;
    end
  end
endmodule

// File: rtl/burst_hdr_rx.sv
module burst_hdr_rx
  import burst_hdr_pkg::*;
#(
  parameter int NUM_DEST = 3,
  parameter int CNT_MOD  = 40,
  parameter int WORD_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WORD_W-1:0]   hdrWord,
  input  logic                hdrSof,
  input  logic                hdrValid,
  input  logic                slotTick,
  output logic [NUM_DEST-1:0] reqValid,
  output logic [REQ_W-1:0]    reqPayload,
  output logic                errPulse
);
  localparam int FRAME_WORDS = HDR_W / WORD_W;

  strobe_t stb;

  burst_hdr_ctrl #(.FRAME_WORDS(FRAME_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrSof(hdrSof), .stb(stb)
  );

  burst_hdr_dp #(
    .NUM_DEST(NUM_DEST), .CNT_MOD(CNT_MOD), .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hdrWord(hdrWord), .slotTick(slotTick), .stb(stb),
    .reqValid(reqValid), .reqPayload(reqPayload), .errPulse(errPulse)
  );
endmodule

// File: rtl/burst_hdr_rx_chk.sv
module burst_hdr_rx_chk
  import burst_hdr_pkg::*;
#(
  parameter int NUM_DEST = 3,
  parameter int CNT_MOD  = 40
) (
  input logic                clk,
  input logic                rstN,
  input logic                hdrSof,
  input logic                hdrValid,
  input logic                slotTick,
  input logic [NUM_DEST-1:0] reqValid,
  input logic                errPulse,
  input logic [SLOT_W-1:0]   slotCnt
);
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqValid));

  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !((|reqValid) && errPulse));

  p_req_after_cont_r1: assert property (@(posedge clk) disable iff (!rstN)
    (|reqValid) |-> $past(hdrValid && !hdrSof));

  p_err_after_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(hdrValid));

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    32'(slotCnt) < CNT_MOD);

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    slotTick |=> (32'(slotCnt) ==
      ((32'($past(slotCnt)) == CNT_MOD - 1) ? 0 : 32'($past(slotCnt)) + 1)));

  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !slotTick |=> $stable(slotCnt));
endmodule

bind burst_hdr_rx burst_hdr_rx_chk #(.NUM_DEST(NUM_DEST), .CNT_MOD(CNT_MOD)) u_chk (
  .clk(clk), .rstN(rstN), .hdrSof(hdrSof), .hdrValid(hdrValid), .slotTick(slotTick),
  .reqValid(reqValid), .errPulse(errPulse), .slotCnt(u_dp.slotCnt)
);

// File: tb/burst_hdr_rx_bench.sv
module burst_hdr_rx_bench;
  localparam int NUM_DEST = 3;
  localparam int CNT_MOD  = 40;
  localparam int WORD_W   = 8;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [WORD_W-1:0]   hdrWord = '0;
  logic                hdrSof = 1'b0;
  logic                hdrValid = 1'b0;
  logic                slotTick = 1'b0;
  logic [NUM_DEST-1:0] reqValid;
  logic [20:0]         reqPayload;
  logic                errPulse;

  int errors = 0;
  int checks = 0;
  int modelCnt = 0;

  always #2 clk = ~clk;

  burst_hdr_rx #(.NUM_DEST(NUM_DEST), .CNT_MOD(CNT_MOD), .WORD_W(WORD_W)) u_burst_hdr_rx (
    .clk(clk), .rstN(rstN), .hdrWord(hdrWord), .hdrSof(hdrSof), .hdrValid(hdrValid),
    .slotTick(slotTick), .reqValid(reqValid), .reqPayload(reqPayload), .errPulse(errPulse)
  );

  function automatic logic [15:0] makeHdr(int chan, int qos, int off, int len, int dest, bit badPar);
    logic [14:0] body;
    logic p;
    body = {3'(chan), 2'(qos), 4'(off), 4'(len), 2'(dest)};
    p = (^body) ^ badPar;
    return {p, body};
  endfunction

  function automatic logic [20:0] expPay(int chan, int qos, int off, int len, int stamp);
    int ts, te;
    ts = (stamp + off) % CNT_MOD;
    te = (ts + len) % CNT_MOD;
    return {3'(chan), 2'(qos), 4'(len), 6'(ts), 6'(te)};
  endfunction

  task automatic checkOut(string tag, logic [NUM_DEST-1:0] expV, logic [20:0] expP, logic expE);
    checks++;
    if (reqValid !== expV || errPulse !== expE || (expV != 0 && reqPayload !== expP)) begin
      errors++;
      $display("FAIL %s: valid=%b pay=%h err=%b expected valid=%b pay=%h err=%b",
               tag, reqValid, reqPayload, errPulse, expV, expP, expE);
    end
  endtask

  task automatic drive(logic [WORD_W-1:0] w, bit sof, bit v, bit tick);
    @(negedge clk);
    hdrWord = w; hdrSof = sof; hdrValid = v; slotTick = tick;
    if (tick) modelCnt = (modelCnt + 1) % CNT_MOD;
  endtask

  task automatic idle();
    drive('0, 1'b0, 1'b0, 1'b0);
  endtask

  // sends a header; on return the outputs of its last word are visible
  task automatic sendHdr(logic [15:0] hdr, bit tickFirst, int gaps, output int stamp);
    stamp = modelCnt;
    drive(hdr[15:8], 1'b1, 1'b1, tickFirst);
    for (int g = 0; g < gaps; g++) idle();
    drive(hdr[7:0], 1'b0, 1'b1, 1'b0);
    idle();
  endtask

  task automatic goodCase(string tag, int chan, int qos, int off, int len, int dest, bit tickFirst, int gaps);
    int stamp;
    sendHdr(makeHdr(chan, qos, off, len, dest, 1'b0), tickFirst, gaps, stamp);
    checkOut(tag, NUM_DEST'(1) << dest, expPay(chan, qos, off, len, stamp), 1'b0);
  endtask

  task automatic printSummary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1: run did not complete, expected completion");
    printSummary();
    $finish;
  end

  initial begin
    int stamp;
    repeat (3) @(negedge clk);
    checkOut("R11 reset", '0, '0, 1'b0);
    rstN = 1'b1;
    idle();
    checkOut("R11 after reset", '0, '0, 1'b0);

    // counter starts at zero: TS equals the offset
    goodCase("R7 R8 first header", 5, 2, 9, 3, 1, 1'b0, 0);

    // sweep every counter value against every offset
    for (int s = 0; s < CNT_MOD; s++) begin
      for (int i = 0; i < 16; i++) begin
        goodCase("R4 R8 R9 R10 sweep", (i + s) % 8, i % 4, i, (i * 7 + s) % 16,
                 (i + s) % NUM_DEST, 1'b0, 0);
      end
      drive('0, 1'b0, 1'b0, 1'b1);
    end
    // counter wrapped back to zero
    goodCase("R7 wrap", 1, 1, 15, 15, 0, 1'b0, 0);

    // extreme sums near the wrap point
    while (modelCnt != CNT_MOD - 1) drive('0, 1'b0, 1'b0, 1'b1);
    goodCase("R9 max wrap", 7, 3, 15, 15, 2, 1'b0, 0);

    // tick in the cycle of the first word: stamp is pre-increment
    goodCase("R8 tick on first word", 2, 0, 4, 6, 1, 1'b1, 0);
    goodCase("R8 tick on first word again", 3, 1, 0, 0, 0, 1'b1, 0);

    // gaps inside a frame
    goodCase("R1 gaps", 6, 2, 3, 8, 2, 1'b0, 3);

    // bad parity for each destination
    for (int d = 0; d < NUM_DEST; d++) begin
      sendHdr(makeHdr(d, 1, 2, 3, d, 1'b1), 1'b0, 0, stamp);
      checkOut("R5 bad parity", '0, '0, 1'b1);
    end
    idle();
    checkOut("R5 pulse is one cycle", '0, '0, 1'b0);

    // destination out of range
    sendHdr(makeHdr(4, 2, 5, 5, 3, 1'b0), 1'b0, 0, stamp);
    checkOut("R6 destination 3", '0, '0, 1'b1);
    sendHdr(makeHdr(4, 2, 5, 5, 3, 1'b1), 1'b0, 0, stamp);
    checkOut("R6 destination 3 bad parity", '0, '0, 1'b1);

    // stray continuation word
    drive(8'h5A, 1'b0, 1'b1, 1'b0);
    idle();
    checkOut("R2 stray word", '0, '0, 1'b1);
    idle();
    checkOut("R2 pulse is one cycle", '0, '0, 1'b0);
    goodCase("R2 recovery", 0, 3, 1, 2, 2, 1'b0, 0);

    // truncated frame: second start-of-frame restarts
    begin
      logic [15:0] hA, hB;
      hA = makeHdr(1, 1, 7, 7, 0, 1'b0);
      hB = makeHdr(5, 3, 11, 9, 1, 1'b0);
      drive(hA[15:8], 1'b1, 1'b1, 1'b0);
      stamp = modelCnt;
      drive(hB[15:8], 1'b1, 1'b1, 1'b0);
      drive(hB[7:0], 1'b0, 1'b1, 1'b0);
      checkOut("R3 truncation error", '0, '0, 1'b1);
      idle();
      checkOut("R3 new frame completes", 3'b010, expPay(5, 3, 11, 9, stamp), 1'b0);
    end
    idle();
    checkOut("R10 single cycle", '0, '0, 1'b0);

    printSummary();
    $finish;
  end
endmodule